// File: doc/BRIEF.md
# Local Countdown Timer with Programmable Divider

This block is the per-core countdown timer of an interrupt controller. Software loads an initial count, picks a clock divisor and programs a timer entry word. The entry word holds the interrupt vector, a mask bit, a delivery-status bit and the choice between one-shot and periodic operation. A prescaler turns the bus clock into count ticks at the chosen divisor. The counter steps down once per tick, and on the tick that takes it from one to zero the timer expires.

On expiry the block pulses a request for one cycle and presents the entry's vector. The request is always a fixed-delivery interrupt, and the mask bit suppresses it. In periodic mode the counter reloads from the initial count and starts again. In one-shot mode it stops. A global software-enable input halts the timer. When the enable returns, counting restarts only if the entry selects periodic mode. A new divisor takes effect only when the counter is next loaded, so a running period keeps its timing.

Top module: `local_timer`

## Requirements
- R1: After reset the entry word (select 2) reads 0x0001_0000, with only the mask bit set. The divide word (select 1), the initial count (select 0) and the current count (select 3) read zero, and no request is raised.
- R2: While enabled, a write of a nonzero value N to the initial count (select 0) loads and starts the counter. The request appears N×D cycles after the write edge, where D is the active divisor. A write of zero stops the timer, no request follows, and the initial count reads zero.
- R3: The current count (select 3) reads N in the cycle after the load and then falls by one per tick. It never exceeds the initial count, and it reads zero whenever the timer is not running.
- R4: The divide word keeps only bits 3, 1 and 0, so writing all ones reads back 0x0B. The index {bit3,bit1,bit0} selects the divisor: values 0 to 6 give 2, 4, 8, 16, 32, 64 and 128, and value 7 gives 1.
- R5: A divide write during a countdown leaves that countdown's timing unchanged. The new divisor applies from the next reload.
- R6: Entry bit 17 set selects periodic mode, in which the counter reloads from the initial count on expiry and the next request follows N×D cycles later. With bit 17 clear the timer stops on expiry and the current count reads zero.
- R7: An expiry raises irq_valid for exactly one cycle and puts entry bits 7:0 on irq_vector. When entry bit 16 (mask) is set, no request is raised. Delivery is always fixed, because no delivery-mode field is stored.
- R8: An entry write keeps only bits 7:0 (vector), bit 12 (delivery status), bit 16 (mask) and bit 17 (periodic). Writing all ones reads back 0x0003_10FF.
- R9: Entry writes made while sw_enable is low are ignored, and the entry reads back unchanged.
- R10: Driving sw_enable low stops the timer, so the current count reads zero and no request follows. Raising it again reloads from the initial count, so the current count reads N one cycle later, but only when the entry selects periodic mode. In one-shot mode the timer stays stopped.
- R11: An initial-count write made while sw_enable is low stores the value but does not start counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Global software enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 initial count, 1 divide, 2 entry |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read target: 0 initial, 1 divide, 2 entry, 3 current count |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
The hardest situation to create is a divisor change that lands in the middle of a running periodic countdown. It must leave the current period alone and alter only the following one. The stimulus starts a periodic countdown at divide-by-one, writes a divide-by-two setting a few cycles later, and then times two consecutive requests against a cycle counter, expecting N and then 2N cycles. A similar sequence toggles the enable with the entry set first to periodic and then to one-shot. It confirms that only the periodic case reloads, and that an entry write made while disabled changes nothing.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int unsigned PRE_W = 7;
    localparam int unsigned VEC_W = 8;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_CUR   = 2'd3
    } lt_sel_e;

    localparam int unsigned DSTAT_BIT = 12;
    localparam int unsigned MASK_BIT  = 16;
    localparam int unsigned PER_BIT   = 17;
    localparam logic [3:0]  DIV_KEEP  = 4'hB;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic             dstat;
        logic [VEC_W-1:0] vector;
    } lt_entry_t;

    localparam lt_entry_t ENTRY_RST = '{periodic: 1'b0, mask: 1'b1,
                                        dstat: 1'b0, vector: '0};

    function automatic lt_entry_t entry_from_word(input logic [31:0] w);
        lt_entry_t e;
        e.vector   = w[VEC_W-1:0];
        e.dstat    = w[DSTAT_BIT];
        e.mask     = w[MASK_BIT];
        e.periodic = w[PER_BIT];
        return e;
    endfunction

    function automatic logic [31:0] entry_to_word(input lt_entry_t e);
        logic [31:0] w;
        w              = '0;
        w[VEC_W-1:0]   = e.vector;
        w[DSTAT_BIT]   = e.dstat;
        w[MASK_BIT]    = e.mask;
        w[PER_BIT]     = e.periodic;
        return w;
    endfunction

    // divisor minus one for a divide code
    function automatic logic [PRE_W-1:0] div_m1_of(input logic [3:0] code);
        logic [2:0] idx;
        int         d;
        idx = {code[3], code[1], code[0]};
        d   = (idx == 3'd7) ? 1 : (2 << idx);
        return PRE_W'(d - 1);
    endfunction

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
    import lt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign tick = run && (st_q.pre == div_m1);

    always_comb begin
        st_d = st_q;
        if (clear || !run || tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lt_entry_regs.sv
module lt_entry_regs
    import lt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enable,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output lt_entry_t         entry,
    output logic [3:0]        div_code
);
    typedef struct packed {
        lt_entry_t  entry;
        logic [3:0] div;
    } regs_t;

    regs_t st_d, st_q;

    assign entry    = st_q.entry;
    assign div_code = st_q.div;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_sel == SEL_DIV)) begin
            st_d.div = wr_data[3:0] & DIV_KEEP;
        end
        if (wr_en && (wr_sel == SEL_ENTRY) && sw_enable) begin
            st_d.entry = entry_from_word(32'(wr_data));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.entry <= ENTRY_RST;
            st_q.div   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_enable,
    input  logic             icr_wr,
    input  logic [CNT_W-1:0] icr_data,
    input  logic             tick,
    input  lt_entry_t        entry,
    input  logic [3:0]       div_code,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] icr,
    output logic [PRE_W-1:0] div_active_m1,
    output logic             reload,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    typedef struct packed {
        logic [CNT_W-1:0] icr;
        logic [CNT_W-1:0] cnt;
        logic             running;
        logic             en;
        logic [PRE_W-1:0] div_m1;
        logic             irq_v;
        logic [VEC_W-1:0] irq_vec;
    } cd_state_t;

    cd_state_t st_d, st_q;

    assign running       = st_q.running;
    assign cnt           = st_q.cnt;
    assign icr           = st_q.icr;
    assign div_active_m1 = st_q.div_m1;
    assign irq_valid     = st_q.irq_v;
    assign irq_vector    = st_q.irq_vec;

    always_comb begin
        st_d       = st_q;
        st_d.en    = sw_enable;
        st_d.irq_v = 1'b0;
        reload     = 1'b0;
        if (!sw_enable) begin
            st_d.running = 1'b0;
            st_d.cnt     = '0;
            if (icr_wr) st_d.icr = icr_data;
        end else if (icr_wr) begin
            st_d.icr = icr_data;
            if (icr_data != '0) begin
                st_d.cnt     = icr_data;
                st_d.running = 1'b1;
                st_d.div_m1  = div_m1_of(div_code);
                reload       = 1'b1;
            end else begin
                st_d.cnt     = '0;
                st_d.running = 1'b0;
            end
        end else if (!st_q.en && entry.periodic && (st_q.icr != '0)) begin
            st_d.cnt     = st_q.icr;
            st_d.running = 1'b1;
            st_d.div_m1  = div_m1_of(div_code);
            reload       = 1'b1;
        end else if (st_q.running && tick) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.irq_v   = !entry.mask;
                st_d.irq_vec = entry.vector;
                if (entry.periodic) begin
                    st_d.cnt    = st_q.icr;
                    st_d.div_m1 = div_m1_of(div_code);
                    reload      = 1'b1;
                end else begin
                    st_d.cnt     = '0;
                    st_d.running = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.div_m1 <= div_m1_of(4'h0);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/local_timer.sv
module local_timer
    import lt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enable,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    lt_entry_t        entry_w;
    logic [3:0]       div_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] icr_w;
    logic [PRE_W-1:0] divm1_w;
    logic             reload_w;
    logic             tick_w;
    logic [31:0]      entry_word_w;

    assign entry_word_w = entry_to_word(entry_w);

    lt_entry_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_enable(sw_enable),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .entry    (entry_w),
        .div_code (div_w)
    );

    lt_prescaler pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .clear (reload_w),
        .div_m1(divm1_w),
        .tick  (tick_w)
    );

    lt_countdown #(.CNT_W(CNT_W)) cd_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_enable    (sw_enable),
        .icr_wr       (wr_en && (wr_sel == SEL_INIT)),
        .icr_data     (wr_data[CNT_W-1:0]),
        .tick         (tick_w),
        .entry        (entry_w),
        .div_code     (div_w),
        .running      (run_w),
        .cnt          (cnt_w),
        .icr          (icr_w),
        .div_active_m1(divm1_w),
        .reload       (reload_w),
        .irq_valid    (irq_valid),
        .irq_vector   (irq_vector)
    );

    always_comb begin
        case (rd_sel)
            SEL_INIT:  rd_data = DATA_W'(icr_w);
            SEL_DIV:   rd_data = DATA_W'(div_w);
            SEL_ENTRY: rd_data = DATA_W'(entry_word_w);
            default:   rd_data = run_w ? DATA_W'(cnt_w) : '0;
        endcase
    end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_enable,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              running,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  icr,
    input logic [31:0]       entry_word,
    input logic              irq_valid
);
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= icr);

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0));

    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(entry_word[16]));

    a_r9_entry_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |=> $stable(entry_word));

    a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |=> (!running && !irq_valid));

    a_r2_zero_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd0) && (wr_data == '0)) |=> !running);
endmodule

bind local_timer lt_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_enable (sw_enable),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .running   (run_w),
    .cnt       (cnt_w),
    .icr       (icr_w),
    .entry_word(entry_word_w),
    .irq_valid (irq_valid)
);

// File: tb/local_timer_tb_top.sv
module local_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    local_timer dut_i (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    // {count, divide code}
    localparam logic [15:0] TBL [0:7] = '{
        {8'd5, 8'h0B}, {8'd3, 8'h00}, {8'd4, 8'h01}, {8'd2, 8'h02},
        {8'd3, 8'h03}, {8'd1, 8'h08}, {8'd2, 8'h09}, {8'd1, 8'h0A}
    };

    function automatic int divisor(input logic [7:0] code);
        int idx;
        idx = {code[3], code[1], code[0]};
        return (idx == 7) ? 1 : (2 << idx);
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp,
                         input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // waits at negedges for a request; elapsed in cycles since t0
    task automatic wait_irq(input int t0, input int limit,
                            output bit seen, output int elapsed);
        seen = 1'b0;
        elapsed = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (irq_valid) begin
                seen = 1'b1;
                elapsed = cyc - t0;
                break;
            end
        end
    endtask

    task automatic idle_no_irq(input int n, input string req);
        bit hit;
        hit = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq_valid) hit = 1'b1;
        end
        check(32'(hit), 32'd0, req);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        bit          seen;
        int          el;
        int          t0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, v); check(v, 32'h0001_0000, "R1 entry reset");
        rd(2'd1, v); check(v, 32'h0, "R1 divide reset");
        rd(2'd0, v); check(v, 32'h0, "R1 initial reset");
        rd(2'd3, v); check(v, 32'h0, "R1 current reset");
        check(32'(irq_valid), 32'd0, "R1 no request");

        // R8 entry field filter, R4 divide filter
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check(v, 32'h0003_10FF, "R8 entry keep");
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check(v, 32'h0000_000B, "R4 divide keep");

        // table: R2 / R4 timing, R7 vector and pulse, R6 one-shot stop
        for (int i = 0; i < 8; i++) begin
            logic [7:0] n;
            logic [7:0] code;
            n    = TBL[i][15:8];
            code = TBL[i][7:0];
            wr(2'd1, 32'(code));
            wr(2'd2, 32'h0000_0040 + 32'(i));
            wr(2'd0, 32'(n));
            t0 = cyc;
            wait_irq(t0, int'(n) * divisor(code) + 20, seen, el);
            check(32'(seen), 32'd1, "R2 request seen");
            check(32'(el), 32'(int'(n) * divisor(code)), "R4 expiry cycle");
            check(32'(irq_vector), 32'h40 + 32'(i), "R7 vector");
            @(negedge clk);
            check(32'(irq_valid), 32'd0, "R7 single-cycle pulse");
            rd(2'd3, v); check(v, 32'h0, "R6 one-shot stopped");
        end

        // R3 current count
        wr(2'd1, 32'h0B);
        wr(2'd2, 32'h0000_0011);
        wr(2'd0, 32'd10);
        rd(2'd3, v); check(v, 32'd10, "R3 count after load");
        repeat (3) @(negedge clk);
        rd(2'd3, v); check(v, 32'd7, "R3 count after three ticks");
        wait_irq(cyc, 30, seen, el);
        @(negedge clk);
        rd(2'd3, v); check(v, 32'd0, "R3 zero when stopped");

        // R5 divide change mid-run, R6 periodic reload
        wr(2'd2, 32'h0002_0021);
        wr(2'd0, 32'd10);
        t0 = cyc;
        repeat (2) @(negedge clk);
        wr(2'd1, 32'h00);
        wait_irq(t0, 40, seen, el);
        check(32'(el), 32'd10, "R5 running period unchanged");
        t0 = cyc;
        wait_irq(t0, 60, seen, el);
        check(32'(seen), 32'd1, "R6 periodic second request");
        check(32'(el), 32'd20, "R5 new divisor after reload");

        // R10 disable, R9 ignored entry write
        @(negedge clk);
        sw_enable = 1'b0;
        @(negedge clk);
        rd(2'd3, v); check(v, 32'd0, "R10 disabled count zero");
        wr(2'd2, 32'h0000_00AA);
        rd(2'd2, v); check(v, 32'h0002_0021, "R9 entry write ignored");
        idle_no_irq(40, "R10 no request while disabled");
        sw_enable = 1'b1;
        @(negedge clk);
        rd(2'd3, v); check(v, 32'd10, "R10 periodic restart");
        t0 = cyc;
        wait_irq(t0, 60, seen, el);
        check(32'(el), 32'd20, "R10 restart timing");

        // R10 one-shot does not restart
        wr(2'd2, 32'h0000_0022);
        @(negedge clk);
        sw_enable = 1'b0;
        repeat (2) @(negedge clk);
        sw_enable = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd3, v); check(v, 32'd0, "R10 one-shot stays stopped");
        idle_no_irq(50, "R10 one-shot no request");

        // R7 mask
        wr(2'd1, 32'h0B);
        wr(2'd2, 32'h0001_0033);
        wr(2'd0, 32'd5);
        idle_no_irq(20, "R7 masked no request");
        rd(2'd3, v); check(v, 32'd0, "R6 masked one-shot stopped");

        // R2 zero write stops
        wr(2'd2, 32'h0002_0044);
        wr(2'd0, 32'd8);
        repeat (3) @(negedge clk);
        wr(2'd0, 32'd0);
        rd(2'd3, v); check(v, 32'd0, "R2 zero stops count");
        rd(2'd0, v); check(v, 32'd0, "R2 initial reads zero");
        idle_no_irq(30, "R2 no request after stop");

        // R11 write while disabled
        @(negedge clk);
        sw_enable = 1'b0;
        wr(2'd0, 32'd6);
        rd(2'd0, v); check(v, 32'd6, "R11 initial stored");
        rd(2'd3, v); check(v, 32'd0, "R11 not counting");
        idle_no_irq(20, "R11 no request");

        summary();
    end
endmodule